// File: doc/BRIEF.md
# Strobe Delay Eye Calibration Engine

This block finds a working strobe timing for an external memory interface without software help. It walks a two-level grid. The outer level is a write-strobe shift value. The output strobe shift always follows it at a fixed offset. The inner level is a delay-line tap, and the same tap is applied to every byte lane. Each grid point is pushed to the memory controller through a one-cycle field-write port, with the controller held stopped while timing fields change. The engine then restarts the controller and waits for the delay line to lock and for initialisation to complete, each wait bounded by a poll limit. After a settling interval it writes a fixed 32-bit test pattern into memory and reads every word back several times.

A point passes when every read-back word matches and the controller's error-correction flag is clear. The engine counts consecutive passing taps within one shift value and remembers the widest run, letting a later run replace an earlier one of equal length. When the grid is done, it programs the winning shift and the midpoint of the winning tap run through the same stop, program, restart, lock, init and settle sequence. It then pulses `done`. A poll that runs out ends the search at once with `err` set and the failing point visible.

Top module: `eye_cal_engine`

## Requirements
- R1: After reset, `done`, `err`, `cfg_we`, `mem_req`, `best_run` and `best_tap` are 0 and `best_shift` equals SHIFT_LO.
- R2: The write shift is stepped from SHIFT_LO to SHIFT_HI by one (default 64 to 95). It is written as field 1 at the first tap of each shift value and at the final point, and is always followed in the next cycle by field 2 carrying the write shift plus OUT_OFS (default 32).
- R3: For each shift, the tap is stepped from TAP_LO to TAP_HI by one (default 1 to 63). At every point, field 3 is written LANES times (lane index 0 to LANES-1 on `cfg_lane`), all with the same tap.
- R4: Field codes are 0 start (value bit 0), 1 write shift, 2 output shift, 3 lane tap and 4 error acknowledge. Each point begins with start=0, and no timing field is written while start is 1. During the sweep, an acknowledge with value 0x3C is written after the timing fields and before start=1.
- R5: After start=1, the engine waits for `dll_lock`, then for `init_done`, then SETTLE_US·CLK_MHZ further cycles before its first memory request.
- R6: If `dll_lock` or `init_done` stays low for POLL_LIMIT cycles, the engine stops, sets `err`, pulses `done`, and leaves the failing shift and tap on `at_shift` and `at_tap`. No memory access is made for that point, and no further point is started. `err` is 0 after a run that ends normally.
- R7: Word i of the test pattern (i = 0 to 63) belongs to group i/16, which holds the pair (00000000, FFFFFFFF), (AAAAAAAA, 55555555), (A5A5A5A5, 5A5A5A5A) or (AA55AA55, 55AA55AA). The second value of the pair is used when bit 1 of i differs from bit 3 of i. Words are written in ascending address order.
- R8: After writing all WORDS words, each word is read READS times in ascending address order. The point fails if any read mismatches or if `ecc_err` is high when the test ends.
- R9: The run length increments on each pass, and is cleared on a fail and at each new shift value. The best window is replaced whenever the new run length is greater than or equal to `best_run`, recording the shift and the first and last tap of the run.
- R10: After the sweep, the final tap is floor((first + last)/2). The final point is programmed without an acknowledge write and without a memory test. `done` is then a single-cycle pulse, and `best_tap` holds the final tap.
- R11: If no point passes, the final point is shift SHIFT_LO with tap 0, and `best_run` is 0.
- R12: `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay stable from the first request cycle until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Starts a search when the engine is idle |
| cfg_we | output | 1 | Field write strobe, one cycle per write |
| cfg_field | output | 3 | Field code (0 start, 1 write shift, 2 output shift, 3 lane tap, 4 acknowledge) |
| cfg_lane | output | $clog2(LANES) | Lane index for field 3 |
| cfg_val | output | SW | Field value |
| dll_lock | input | 1 | Delay line locked |
| init_done | input | 1 | Controller initialisation complete |
| ecc_err | input | 1 | Controller error-correction error status |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | $clog2(WORDS) | Word address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access completed, read data valid |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | One-cycle end-of-search pulse |
| err | output | 1 | Poll timeout occurred |
| at_shift | output | SW | Shift of the point being tried, or of the failing point |
| at_tap | output | TW | Tap of the point being tried, or of the failing point |
| best_run | output | TW | Length of the widest passing run |
| best_shift | output | SW | Shift of the widest passing run |
| best_tap | output | TW | Final centred tap |

## Verification
The bench builds the engine with three shift values (4 to 6), seven taps (1 to 7), the full 64-word pattern, two reads per word, a poll limit of 40 and a six-cycle settle. With these values a whole grid finishes in a few thousand cycles, so several complete searches fit in one run. They bring within reach tie-breaking across and within shift values, run clearing at a shift boundary, the empty-window case, error-flag failures, second-read-only corruption, and timeouts on either poll.

// File: rtl/eye_cal_engine.sv
module eye_cal_engine #(
  parameter int SHIFT_LO   = 64,
  parameter int SHIFT_HI   = 95,
  parameter int OUT_OFS    = 32,
  parameter int TAP_LO     = 1,
  parameter int TAP_HI     = 63,
  parameter int LANES      = 9,
  parameter int WORDS      = 64,
  parameter int READS      = 2,
  parameter int POLL_LIMIT = 65535,
  parameter int CLK_MHZ    = 200,
  parameter int SETTLE_US  = 100,
  parameter int SW         = 7,
  parameter int TW         = 6,
  localparam int AW        = $clog2(WORDS),
  localparam int LW        = $clog2(LANES),
  localparam int RW        = $clog2(READS) + 1,
  localparam int SETTLE_CYC = CLK_MHZ * SETTLE_US,
  localparam int CW        = $clog2((POLL_LIMIT > SETTLE_CYC) ? POLL_LIMIT : SETTLE_CYC) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  output logic          cfg_we,
  output logic [2:0]    cfg_field,
  output logic [LW-1:0] cfg_lane,
  output logic [SW-1:0] cfg_val,
  input  logic          dll_lock,
  input  logic          init_done,
  input  logic          ecc_err,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic          done,
  output logic          err,
  output logic [SW-1:0] at_shift,
  output logic [TW-1:0] at_tap,
  output logic [TW-1:0] best_run,
  output logic [SW-1:0] best_shift,
  output logic [TW-1:0] best_tap
);

  typedef enum logic [3:0] {
    S_IDLE, S_OFF, S_WSH, S_OSH, S_LANE, S_ACK, S_ON, S_LOCK,
    S_INIT, S_SETL, S_WR, S_RD, S_EVAL, S_NEXT, S_DONE
  } st_t;

  st_t st;
  logic [TW-1:0] run_q, win_s, bst_s, bst_e;
  logic          new_sh, fin_q, bad_q;
  logic [AW-1:0] idx_q;
  logic [RW-1:0] rep_q;
  logic [LW-1:0] lane_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [31:0] pat_word(input logic [5:0] w);
    logic hi;
    hi = w[1] ^ w[3];
    case (w[5:4])
      2'd0:    return hi ? 32'hFFFF_FFFF : 32'h0000_0000;
      2'd1:    return hi ? 32'h5555_5555 : 32'hAAAA_AAAA;
      2'd2:    return hi ? 32'h5A5A_5A5A : 32'hA5A5_A5A5;
      default: return hi ? 32'h55AA_55AA : 32'hAA55_AA55;
    endcase
  endfunction

  wire            pass  = !bad_q && !ecc_err;
  wire [TW-1:0]   run_n = run_q + TW'(1);
  wire [TW-1:0]   ws_n  = (run_q == '0) ? at_tap : win_s;
  wire [TW:0]     tsum  = {1'b0, bst_s} + {1'b0, bst_e};
  wire            last_w = (idx_q == AW'(WORDS - 1));

  assign cfg_we    = st inside {S_OFF, S_WSH, S_OSH, S_LANE, S_ACK, S_ON};
  assign cfg_lane  = lane_q;
  assign mem_req   = (st == S_WR) || (st == S_RD);
  assign mem_we    = (st == S_WR);
  assign mem_addr  = idx_q;
  assign mem_wdata = pat_word(6'(idx_q));
  assign done      = (st == S_DONE);

  always_comb begin
    cfg_field = 3'd0;
    cfg_val   = '0;
    case (st)
      S_WSH:  begin cfg_field = 3'd1; cfg_val = at_shift; end
      S_OSH:  begin cfg_field = 3'd2; cfg_val = at_shift + SW'(OUT_OFS); end
      S_LANE: begin cfg_field = 3'd3; cfg_val = SW'(at_tap); end
      S_ACK:  begin cfg_field = 3'd4; cfg_val = SW'(8'h3C); end
      S_ON:   begin cfg_field = 3'd0; cfg_val = SW'(1); end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;  err <= 1'b0;
      at_shift <= SW'(SHIFT_LO);  at_tap <= TW'(TAP_LO);
      best_run <= '0;  best_shift <= SW'(SHIFT_LO);  best_tap <= '0;
      run_q <= '0;  win_s <= '0;  bst_s <= '0;  bst_e <= '0;
      new_sh <= 1'b1;  fin_q <= 1'b0;  bad_q <= 1'b0;
      idx_q <= '0;  rep_q <= '0;  lane_q <= '0;  cnt_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (go) begin
          at_shift <= SW'(SHIFT_LO);  at_tap <= TW'(TAP_LO);
          best_run <= '0;  best_shift <= SW'(SHIFT_LO);  best_tap <= '0;
          run_q <= '0;  bst_s <= '0;  bst_e <= '0;
          new_sh <= 1'b1;  fin_q <= 1'b0;  err <= 1'b0;
          st <= S_OFF;
        end
        S_OFF: begin
          lane_q <= '0;
          st <= (new_sh || fin_q) ? S_WSH : S_LANE;
        end
        S_WSH: st <= S_OSH;
        S_OSH: st <= S_LANE;
        S_LANE:
          if (lane_q == LW'(LANES - 1)) st <= fin_q ? S_ON : S_ACK;
          else lane_q <= lane_q + LW'(1);
        S_ACK: st <= S_ON;
        S_ON: begin cnt_q <= '0; st <= S_LOCK; end
        S_LOCK:
          if (dll_lock) begin cnt_q <= '0; st <= S_INIT; end
          else if (cnt_q == CW'(POLL_LIMIT - 1)) begin err <= 1'b1; st <= S_DONE; end
          else cnt_q <= cnt_q + CW'(1);
        S_INIT:
          if (init_done) begin cnt_q <= '0; st <= S_SETL; end
          else if (cnt_q == CW'(POLL_LIMIT - 1)) begin err <= 1'b1; st <= S_DONE; end
          else cnt_q <= cnt_q + CW'(1);
        S_SETL:
          if (cnt_q == CW'(SETTLE_CYC - 1)) begin
            if (fin_q) st <= S_DONE;
            else begin idx_q <= '0; bad_q <= 1'b0; st <= S_WR; end
          end else cnt_q <= cnt_q + CW'(1);
        S_WR: if (mem_ack) begin
          if (last_w) begin idx_q <= '0; rep_q <= '0; st <= S_RD; end
          else idx_q <= idx_q + AW'(1);
        end
        S_RD: if (mem_ack) begin
          if (mem_rdata != mem_wdata) bad_q <= 1'b1;
          if (rep_q == RW'(READS - 1)) begin
            rep_q <= '0;
            if (last_w) st <= S_EVAL;
            else idx_q <= idx_q + AW'(1);
          end else rep_q <= rep_q + RW'(1);
        end
        S_EVAL: begin
          if (pass) begin
            run_q <= run_n;
            win_s <= ws_n;
            if (run_n >= best_run) begin
              best_run <= run_n;  best_shift <= at_shift;
              bst_s <= ws_n;      bst_e <= at_tap;
            end
          end else run_q <= '0;
          st <= S_NEXT;
        end
        S_NEXT: begin
          st <= S_OFF;
          if (at_tap == TW'(TAP_HI)) begin
            if (at_shift == SW'(SHIFT_HI)) begin
              fin_q <= 1'b1;
              at_shift <= best_shift;
              at_tap <= tsum[TW:1];
              best_tap <= tsum[TW:1];
            end else begin
              at_shift <= at_shift + SW'(1);
              at_tap <= TW'(TAP_LO);
              run_q <= '0;
              new_sh <= 1'b1;
            end
          end else begin
            at_tap <= at_tap + TW'(1);
            new_sh <= 1'b0;
          end
        end
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r2_out_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_field == 3'd2) |-> ($past(cfg_we) && $past(cfg_field) == 3'd1
      && cfg_val == $past(cfg_val) + SW'(OUT_OFS)));

  a_r3_tap_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_field == 3'd3 && !fin_q) |->
      (cfg_val >= SW'(TAP_LO) && cfg_val <= SW'(TAP_HI)));

  a_r5_mem_after_init: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> init_done);

  a_r6_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> done);

  a_r9_best_never_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && $past(st) != S_IDLE) |-> best_run >= $past(best_run));

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r12_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
      && $stable(mem_wdata)));

endmodule

// File: tb/eye_cal_engine_bench.sv
module eye_cal_engine_bench;
  localparam int CLK_P = 10;
  localparam int SLO = 4, SHI = 6, TLO = 1, THI = 7;
  localparam int NT = THI - TLO + 1;
  localparam int PTS = (SHI - SLO + 1) * NT;
  localparam int NW = 64, NR = 2, SETL = 6;

  // row: [40:20] pass mask (bit (shift-4)*7 + tap-1), [19] ecc mode, [18:13] run, [12:6] shift, [5:0] tap
  localparam logic [40:0] ROWS [5] = '{
    {7'b0000011, 7'b0111100, 7'b0001110, 1'b0, 6'd4, 7'd5, 6'd4},
    {7'b0000000, 7'b1110000, 7'b0000111, 1'b0, 6'd3, 7'd5, 6'd6},
    {7'b0000000, 7'b0000000, 7'b0110011, 1'b0, 6'd2, 7'd4, 6'd5},
    {7'b0000000, 7'b0000000, 7'b0000000, 1'b0, 6'd0, 7'd4, 6'd0},
    {7'b0001000, 7'b0000011, 7'b1100000, 1'b1, 6'd2, 7'd5, 6'd1}
  };

  logic clk = 0, rst_n = 0, go = 0;
  logic cfg_we; logic [2:0] cfg_field; logic [3:0] cfg_lane; logic [6:0] cfg_val;
  logic dll_lock = 0, init_done = 0, ecc_err = 0;
  logic mem_req, mem_we; logic [5:0] mem_addr; logic [31:0] mem_wdata;
  logic mem_ack = 0; logic [31:0] mem_rdata = 0;
  logic done, err; logic [6:0] at_shift, best_shift; logic [5:0] at_tap, best_run, best_tap;

  eye_cal_engine #(.SHIFT_LO(SLO), .SHIFT_HI(SHI), .OUT_OFS(32), .TAP_LO(TLO), .TAP_HI(THI),
    .LANES(9), .WORDS(NW), .READS(NR), .POLL_LIMIT(40), .CLK_MHZ(1), .SETTLE_US(SETL),
    .SW(7), .TW(6)) u_eye_cal_engine (
    .clk, .rst_n, .go, .cfg_we, .cfg_field, .cfg_lane, .cfg_val, .dll_lock, .init_done,
    .ecc_err, .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_ack, .mem_rdata, .done, .err,
    .at_shift, .at_tap, .best_run, .best_shift, .best_tap);

  always #(CLK_P/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_word(input int a);
    int k; bit sec;
    k = a % 16;
    sec = (k == 2 || k == 3 || k == 6 || k == 7 || k == 8 || k == 9 || k == 12 || k == 13);
    case (a / 16)
      0: return sec ? 32'hFFFFFFFF : 32'h00000000;
      1: return sec ? 32'h55555555 : 32'hAAAAAAAA;
      2: return sec ? 32'h5A5A5A5A : 32'hA5A5A5A5;
      default: return sec ? 32'h55AA55AA : 32'hAA55AA55;
    endcase
  endfunction

  // stimulus set by tasks
  logic [20:0] mask = 0; logic ecc_mode = 0; int kill_kind = 0, kill_pt = -1;
  // model state
  logic sh_start = 0; logic [6:0] sh_w = 0, sh_o = 0; logic [6:0] lanes [9];
  logic [8:0] lane_wr = 0; logic ack_seen = 0, cur_pass = 0, seen_op = 0, hold = 0, h_we = 0;
  logic [5:0] h_addr = 0;
  int pt = 0, cur_pt = 0, on_t = 0, init_t = 0, cyc = 0, wr_n = 0, rd_n = 0;
  int rdc [64];
  logic [31:0] mem [64];
  logic [6:0] fin_w = 0, fin_t = 0; logic fin_ack = 0;
  logic seq_bad = 0, shift_bad = 0, tap_bad = 0, ops_bad = 0, pat_bad = 0, settle_bad = 0, hs_bad = 0;

  always @(negedge clk) begin
    cyc++;
    if (go) begin
      pt = 0; seq_bad = 0; shift_bad = 0; tap_bad = 0; ops_bad = 0; pat_bad = 0;
      settle_bad = 0; hs_bad = 0; fin_w = 0; fin_t = 0; fin_ack = 0; lane_wr = 0;
    end
    if (cfg_we) begin
      case (cfg_field)
        3'd0: if (!cfg_val[0]) begin
          sh_start = 0; dll_lock = 0; init_done = 0; ecc_err = 0;
        end else begin
          if (pt > 0 && pt <= PTS && (wr_n != NW || rd_n != NW * NR)) ops_bad = 1;
          for (int l = 0; l < 9; l++) if (lanes[l] != lanes[0]) tap_bad = 1;
          if (lane_wr != 9'h1FF) tap_bad = 1;
          if (sh_o != sh_w + 7'd32) shift_bad = 1;
          if (pt < PTS) begin
            if (sh_w != 7'(SLO + pt / NT)) shift_bad = 1;
            if (lanes[0] != 7'(TLO + pt % NT)) tap_bad = 1;
            if (!ack_seen) seq_bad = 1;
            cur_pass = mask[pt];
            ecc_err = ecc_mode && !cur_pass;
          end else begin
            fin_w = sh_w; fin_t = lanes[0]; fin_ack = ack_seen;
          end
          cur_pt = pt; pt++; ack_seen = 0; sh_start = 1; on_t = cyc;
          wr_n = 0; rd_n = 0; seen_op = 0; lane_wr = 0;
          for (int a = 0; a < 64; a++) rdc[a] = 0;
        end
        3'd1: begin if (sh_start) seq_bad = 1; sh_w = cfg_val; end
        3'd2: begin if (sh_start) seq_bad = 1; sh_o = cfg_val; end
        3'd3: begin if (sh_start) seq_bad = 1; lanes[cfg_lane] = cfg_val; lane_wr[cfg_lane] = 1; end
        3'd4: begin if (cfg_val != 7'h3C) seq_bad = 1; ack_seen = 1; ecc_err = 0; end
        default: seq_bad = 1;
      endcase
    end
    if (sh_start && !dll_lock && !(kill_kind == 1 && cur_pt == kill_pt) && cyc >= on_t + 3)
      dll_lock = 1;
    else if (dll_lock && !init_done && !(kill_kind == 2 && cur_pt == kill_pt) && cyc >= on_t + 5) begin
      init_done = 1; init_t = cyc;
    end
    if (mem_ack) mem_ack = 0;
    else if (mem_req) begin
      if (!seen_op) begin
        seen_op = 1;
        if (!init_done || cyc - init_t < SETL) settle_bad = 1;
      end
      if (hold && (mem_addr != h_addr || mem_we != h_we)) hs_bad = 1;
      if (!hold) begin
        hold = 1; h_addr = mem_addr; h_we = mem_we;
      end else begin
        hold = 0; mem_ack = 1;
        if (mem_we) begin
          mem[mem_addr] = mem_wdata; wr_n++;
          if (mem_wdata != ref_word(int'(mem_addr))) pat_bad = 1;
        end else begin
          rd_n++;
          mem_rdata = mem[mem_addr] ^
            ((!ecc_mode && !cur_pass && mem_addr == 6'd5 && rdc[5] == 1) ? 32'h1 : 32'h0);
          rdc[mem_addr]++;
        end
      end
    end else if (hold) hs_bad = 1;
  end

  task automatic run_search(input logic [20:0] m, input logic em, input int kk, input int kp,
                            output bit hung);
    int n;
    @(negedge clk); #1;
    mask = m; ecc_mode = em; kill_kind = kk; kill_pt = kp; go = 1;
    @(negedge clk); #1; go = 0;
    n = 0;
    while (!done && n < 40000) begin @(negedge clk); #1; n++; end
    hung = !done;
    check(!hung, "R10 done seen", done, 1);
    @(negedge clk); #1;
    check(!done, "R10 done one cycle", done, 0);
  endtask

  task automatic sweep_checks();
    check(!shift_bad, "R2 shift sweep", shift_bad, 0);
    check(!tap_bad, "R3 lane taps", tap_bad, 0);
    check(!seq_bad, "R4 write order", seq_bad, 0);
    check(!settle_bad, "R5 settle wait", settle_bad, 0);
    check(!pat_bad, "R7 pattern", pat_bad, 0);
    check(!ops_bad, "R8 access counts", ops_bad, 0);
    check(!hs_bad, "R12 handshake", hs_bad, 0);
  endtask

  initial begin
    bit hung;
    for (int l = 0; l < 9; l++) lanes[l] = 0;
    for (int a = 0; a < 64; a++) begin rdc[a] = 0; mem[a] = 0; end
    repeat (3) @(negedge clk);
    #1;
    check(!done && !err && !cfg_we && !mem_req, "R1 reset outputs",
          {done, err, cfg_we, mem_req}, 0);
    check(best_run == 0 && best_tap == 0 && best_shift == 7'(SLO), "R1 reset best",
          best_shift, SLO);
    rst_n = 1;

    for (int i = 0; i < 5; i++) begin
      run_search(ROWS[i][40:20], ROWS[i][19], 0, -1, hung);
      sweep_checks();
      check(err == 0, "R6 no error", err, 0);
      check(best_run == ROWS[i][18:13], "R9 best run", best_run, ROWS[i][18:13]);
      check(best_shift == ROWS[i][12:6], "R9 best shift", best_shift, ROWS[i][12:6]);
      check(best_tap == ROWS[i][5:0], "R10 best tap", best_tap, ROWS[i][5:0]);
      check(fin_w == ROWS[i][12:6], "R10 final shift written", fin_w, ROWS[i][12:6]);
      check(fin_t == 7'(ROWS[i][5:0]), "R10 final tap written", fin_t, ROWS[i][5:0]);
      check(!fin_ack && wr_n == 0 && rd_n == 0, "R10 final no ack no test", wr_n + rd_n, 0);
      if (ROWS[i][18:13] == 0)
        check(fin_w == 7'(SLO) && fin_t == 0, "R11 empty window", fin_t, 0);
    end

    run_search(21'h1FFFFF, 1'b0, 1, 9, hung);
    check(err == 1, "R6 lock timeout err", err, 1);
    check(at_shift == 7'd5 && at_tap == 6'd3, "R6 lock timeout point",
          {at_shift, at_tap}, {7'd5, 6'd3});
    check(pt == 10 && wr_n == 0, "R6 lock timeout stops", pt, 10);

    run_search(21'h1FFFFF, 1'b0, 2, 15, hung);
    check(err == 1, "R6 init timeout err", err, 1);
    check(at_shift == 7'd6 && at_tap == 6'd2, "R6 init timeout point",
          {at_shift, at_tap}, {7'd6, 6'd2});
    check(pt == 16 && wr_n == 0, "R6 init timeout stops", pt, 16);

    run_search(ROWS[1][40:20], ROWS[1][19], 0, -1, hung);
    sweep_checks();
    check(err == 0, "R6 err cleared on restart", err, 0);
    check(best_run == 6'd3 && best_shift == 7'd5 && best_tap == 6'd6, "R9 restart result",
          best_tap, 6);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    n_bad++;
    $display("FAIL R10 watchdog: actual 0 expected 1 (done)");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule